// File: doc/BRIEF.md
# Set-Associative Read Cache with LRU Replacement

This block is a read-only cache that sits between a load requester and a slow main memory. Its data store holds a fixed number of bytes organised as multi-word blocks. The associativity is a parameter of 2 or 4. An address picks one set through its index bits, and every way of that set compares its stored tag against the address in the same cycle. A valid way whose tag matches is a hit. The hit returns the addressed word, or one zero-extended byte, in the cycle after the request is accepted.

On a miss the cache drops its ready signal and picks a victim way in the set. The lowest-numbered invalid way is used if one exists; otherwise the least recently used way is taken. The cache then reads the whole block from memory one word at a time. Memory answers each word read a fixed number of cycles after the read is issued. When the block is complete, the line becomes valid and the requested data is returned. Every hit and every fill makes the accessed way the most recent in its set.

Each response also reports how it was served: a hit, a cold miss into an empty way, or a miss that evicted a valid line. This lets a test environment compare the cache with a reference model access by access. With the defaults (1 KB, 4-word blocks), two ways give 32 sets with a 5-bit index and a 23-bit tag. Four ways give 16 sets, one index bit fewer and one tag bit more.

Top module: `setassoc_lru_cache`

## Requirements
- R1: The address splits, from the least significant bit, into a 2-bit byte offset, a 2-bit word-in-block offset, an index of log2(sets) bits and the remaining tag bits. Addresses with equal index and different tags compete for the ways of the same set.
- R2: A lookup hits only when a valid way of the indexed set holds the address tag. After reset no way is valid, so every access misses.
- R3: An accepted request that hits gives resp_valid=1, resp_hit=1 and resp_kind=2'b00 in the next cycle, with no memory read.
- R4: An accepted request that misses sets req_ready low from the next cycle until the response. It issues exactly one memory read per block word (word 0 first), with each read's data taken MEM_LAT cycles after the read. The response appears BLOCK_WORDS*(MEM_LAT+1)+1 cycles after acceptance, in a cycle where req_ready is 1 again.
- R5: A fill loads every word of the block, so later word or byte loads anywhere in that block hit and return the memory contents.
- R6: A miss in a set that still has an invalid way fills the lowest-numbered invalid way and reports resp_kind=2'b01 (cold).
- R7: A miss in a set whose ways are all valid replaces the least recently used way and reports resp_kind=2'b10 (eviction).
- R8: Every hit and every fill makes the accessed way the most recently used in its set, and only the ways that were more recent than it age by one.
- R9: A word load (req_byte=0) returns the full 32-bit word and ignores address bits [1:0]. A byte load (req_byte=1) returns byte lane addr[1:0], where lane k is data bits [8k+7:8k], zero-extended to 32 bits.
- R10: At most one way of a set ever matches a lookup tag.
- R11: During and right after reset, req_ready=1, resp_valid=0 and mem_rd_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Byte address of the load |
| req_byte | input | 1 | 1 = byte load, 0 = word load |
| req_ready | output | 1 | Cache can take a request this cycle |
| resp_valid | output | 1 | Response present for one cycle |
| resp_hit | output | 1 | Response was served from the cache |
| resp_kind | output | 2 | 00 hit, 01 cold miss, 10 eviction miss |
| resp_data | output | DATA_W | Loaded word or zero-extended byte |
| mem_rd_en | output | 1 | One-cycle word read to main memory |
| mem_rd_addr | output | ADDR_W | Word-aligned address of the memory read |
| mem_rd_data | input | DATA_W | Memory data, valid MEM_LAT cycles after the read |

## Verification
A fixed list of word and byte loads targets one set with three different tags. This fills the empty ways first, then forces evictions whose victim depends on which way was refreshed by a recent hit, so a model of recency order tells a true LRU choice apart from a fixed or round-robin one. Other entries touch the top and bottom of the address space and several offsets inside one block. These tell whether the whole block was filled, whether the byte lane was selected correctly, and whether the tag and index bits were split in the right place. A reset in the middle of the run followed by a reload of a cached address shows that the valid state is cleared. The stall length and the number of memory reads are checked on every miss.

// File: rtl/setassoc_cache_pkg.sv
package setassoc_cache_pkg;

    typedef enum logic [1:0] {
        KIND_HIT   = 2'b00,
        KIND_COLD  = 2'b01,
        KIND_EVICT = 2'b10
    } miss_kind_e;

    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } cache_state_e;

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 23,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            match_vec,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       any_free,
    output logic [WAY_W-1:0]           free_way
);

    // One comparator per way, all working on the same set at once.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_vec[g] = set_valid[g] && (set_tags[g] == look_tag);
    end

    // Encode the matching way and the lowest-numbered empty way.
    always_comb begin
        any_hit  = |match_vec;
        hit_way  = '0;
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                hit_way = WAY_W'(w);
            end
            if (!set_valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/cache_lru_tracker.sv
module cache_lru_tracker #(
    parameter int WAYS  = 2,
    parameter int SETS  = 32,
    parameter int WAY_W = 1,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim_way
);

    // Least recently used way of every set.
    logic [SETS-1:0][WAY_W-1:0] lru_vec;

    if (WAYS == 2) begin : g_pair
        // One bit per set names the way that was touched less recently.
        logic [SETS-1:0] lru_bit_d, lru_bit_q;

        always_comb begin
            lru_bit_d = lru_bit_q;
            if (upd_en) begin
                lru_bit_d[upd_set] = ~upd_way[0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lru_bit_q <= '0;
            end else begin
                lru_bit_q <= lru_bit_d;
            end
        end

        for (genvar s = 0; s < SETS; s++) begin : g_vec
            assign lru_vec[s] = WAY_W'(lru_bit_q[s]);
        end
    end else begin : g_ages
        // Each way carries an age; 0 is the newest, WAYS-1 the oldest.
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_d, age_q;

        always_comb begin
            age_d = age_q;
            if (upd_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == upd_way) begin
                        age_d[upd_set][w] = '0;
                    end else if (age_q[upd_set][w] < age_q[upd_set][upd_way]) begin
                        age_d[upd_set][w] = age_q[upd_set][w] + 1'b1;
                    end
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        age_q[s][w] <= WAY_W'(w);
                    end
                end
            end else begin
                age_q <= age_d;
            end
        end

        always_comb begin
            for (int s = 0; s < SETS; s++) begin
                lru_vec[s] = '0;
                for (int w = 0; w < WAYS; w++) begin
                    if (age_q[s][w] == WAY_W'(WAYS - 1)) begin
                        lru_vec[s] = WAY_W'(w);
                    end
                end
            end
        end
    end

    assign victim_way = lru_vec[rd_set];

    // R8: a way just touched can never be the next victim of its set.
    assert_mru_not_victim_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        upd_en |=> (lru_vec[$past(upd_set)] != $past(upd_way))
    );

endmodule

// File: rtl/setassoc_lru_cache.sv
module setassoc_lru_cache
    import setassoc_cache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CACHE_BYTES = 1024,
    parameter int BLOCK_WORDS = 4,
    parameter int WAYS        = 2,
    parameter int MEM_LAT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_byte,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [1:0]        resp_kind,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BOFF_W     = $clog2(WORD_BYTES);
    localparam int WOFF_W     = $clog2(BLOCK_WORDS);
    localparam int LINES      = CACHE_BYTES / (WORD_BYTES * BLOCK_WORDS);
    localparam int SETS       = LINES / WAYS;
    localparam int IDX_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - IDX_W - WOFF_W - BOFF_W;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int LAT_W      = $clog2(MEM_LAT + 1);

    typedef struct packed {
        cache_state_e       state;
        logic [TAG_W-1:0]   miss_tag;
        logic [IDX_W-1:0]   miss_idx;
        logic [WOFF_W-1:0]  miss_word;
        logic [BOFF_W-1:0]  miss_boff;
        logic               miss_is_byte;
        logic [WAY_W-1:0]   miss_way;
        miss_kind_e         miss_kind;
        logic [WOFF_W-1:0]  wcnt;
        logic [LAT_W-1:0]   lcnt;
        logic               resp_valid;
        logic               resp_hit;
        miss_kind_e         resp_kind;
        logic [DATA_W-1:0]  resp_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Line storage: tags and valid bits are reset, data words are not.
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]                 tag_d, tag_q;
    logic [SETS-1:0][WAYS-1:0]                            valid_d, valid_q;
    logic [SETS-1:0][WAYS-1:0][BLOCK_WORDS-1:0][DATA_W-1:0] data_d, data_q;

    // Address fields of the incoming request.
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WOFF_W-1:0] req_word;
    logic [BOFF_W-1:0] req_boff;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[BOFF_W + WOFF_W +: IDX_W];
    assign req_word = req_addr[BOFF_W +: WOFF_W];
    assign req_boff = req_addr[0 +: BOFF_W];

    // Parallel tag lookup over the indexed set.
    logic [WAYS-1:0]  way_match;
    logic             lookup_hit;
    logic [WAY_W-1:0] hit_way;
    logic             set_has_free;
    logic [WAY_W-1:0] free_way;

    cache_tag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) u_match (
        .set_tags  (tag_q[req_idx]),
        .set_valid (valid_q[req_idx]),
        .look_tag  (req_tag),
        .match_vec (way_match),
        .any_hit   (lookup_hit),
        .hit_way   (hit_way),
        .any_free  (set_has_free),
        .free_way  (free_way)
    );

    // Recency state, read for the victim and written on hits and fills.
    logic             lru_upd;
    logic [IDX_W-1:0] lru_set;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] lru_victim;

    cache_lru_tracker #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .WAY_W (WAY_W),
        .IDX_W (IDX_W)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (lru_upd),
        .upd_set    (lru_set),
        .upd_way    (lru_way),
        .rd_set     (req_idx),
        .victim_way (lru_victim)
    );

    // Select a zero-extended byte lane or pass the whole word.
    function automatic logic [DATA_W-1:0] pick_lane(
        input logic [DATA_W-1:0] word,
        input logic              is_byte,
        input logic [BOFF_W-1:0] boff
    );
        logic [DATA_W-1:0] res;
        res = word;
        if (is_byte) begin
            res = {{(DATA_W-8){1'b0}}, word[{boff, 3'b000} +: 8]};
        end
        return res;
    endfunction

    assign req_ready   = (ctl_q.state == ST_LOOKUP);
    assign mem_rd_addr = {ctl_q.miss_tag, ctl_q.miss_idx, ctl_q.wcnt, {BOFF_W{1'b0}}};

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.resp_valid = 1'b0;
        tag_d            = tag_q;
        valid_d          = valid_q;
        data_d           = data_q;
        lru_upd          = 1'b0;
        lru_set          = req_idx;
        lru_way          = hit_way;
        mem_rd_en        = 1'b0;

        case (ctl_q.state)
            ST_LOOKUP: begin
                if (req_valid) begin
                    if (lookup_hit) begin
                        ctl_d.resp_valid = 1'b1;
                        ctl_d.resp_hit   = 1'b1;
                        ctl_d.resp_kind  = KIND_HIT;
                        ctl_d.resp_data  = pick_lane(data_q[req_idx][hit_way][req_word],
                                                     req_byte, req_boff);
                        lru_upd          = 1'b1;
                    end else begin
                        ctl_d.state        = ST_FILL;
                        ctl_d.miss_tag     = req_tag;
                        ctl_d.miss_idx     = req_idx;
                        ctl_d.miss_word    = req_word;
                        ctl_d.miss_boff    = req_boff;
                        ctl_d.miss_is_byte = req_byte;
                        ctl_d.miss_way     = set_has_free ? free_way : lru_victim;
                        ctl_d.miss_kind    = set_has_free ? KIND_COLD : KIND_EVICT;
                        ctl_d.wcnt         = '0;
                        ctl_d.lcnt         = '0;
                        valid_d[req_idx][ctl_d.miss_way] = 1'b0;
                    end
                end
            end
            ST_FILL: begin
                mem_rd_en = (ctl_q.lcnt == '0);
                if (ctl_q.lcnt == LAT_W'(MEM_LAT)) begin
                    data_d[ctl_q.miss_idx][ctl_q.miss_way][ctl_q.wcnt] = mem_rd_data;
                    if (ctl_q.wcnt == ctl_q.miss_word) begin
                        ctl_d.resp_data = pick_lane(mem_rd_data, ctl_q.miss_is_byte,
                                                    ctl_q.miss_boff);
                    end
                    ctl_d.lcnt = '0;
                    if (ctl_q.wcnt == WOFF_W'(BLOCK_WORDS - 1)) begin
                        tag_d[ctl_q.miss_idx][ctl_q.miss_way]   = ctl_q.miss_tag;
                        valid_d[ctl_q.miss_idx][ctl_q.miss_way] = 1'b1;
                        lru_upd          = 1'b1;
                        lru_set          = ctl_q.miss_idx;
                        lru_way          = ctl_q.miss_way;
                        ctl_d.resp_valid = 1'b1;
                        ctl_d.resp_hit   = 1'b0;
                        ctl_d.resp_kind  = ctl_q.miss_kind;
                        ctl_d.state      = ST_LOOKUP;
                    end else begin
                        ctl_d.wcnt = ctl_q.wcnt + 1'b1;
                    end
                end else begin
                    ctl_d.lcnt = ctl_q.lcnt + 1'b1;
                end
            end
            default: ctl_d.state = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_LOOKUP;
            tag_q       <= '0;
            valid_q     <= '0;
        end else begin
            ctl_q   <= ctl_d;
            tag_q   <= tag_d;
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign resp_valid = ctl_q.resp_valid;
    assign resp_hit   = ctl_q.resp_hit;
    assign resp_kind  = ctl_q.resp_kind;
    assign resp_data  = ctl_q.resp_data;

    // R10: tags within one set never alias.
    assert_single_match_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> $onehot0(way_match)
    );

    // R3: a hit answers in the following cycle.
    assert_hit_next_cycle_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lookup_hit) |=> (resp_valid && resp_hit)
    );

    // R4: a miss stalls the requester and starts a memory read at once.
    assert_miss_stalls_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lookup_hit) |=> (!req_ready && mem_rd_en)
    );

    // R4: responses only appear when the cache is free again.
    assert_resp_when_ready_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready
    );

    // R4: no memory traffic while lookups are being served.
    assert_no_read_in_lookup_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en
    );

endmodule

// File: tb/setassoc_lru_cache_bench.sv
module setassoc_lru_cache_bench;

    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int CACHE_BYTES = 1024;
    localparam int BLOCK_WORDS = 4;
    localparam int WAYS        = 2;
    localparam int MEM_LAT     = 3;
    localparam int LINES       = CACHE_BYTES / (4 * BLOCK_WORDS);
    localparam int SETS        = LINES / WAYS;
    localparam int IDX_W       = $clog2(SETS);
    localparam int LOW_W       = 2 + $clog2(BLOCK_WORDS);
    localparam int MISS_LAT    = BLOCK_WORDS * (MEM_LAT + 1) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_byte = 1'b0;
    logic              req_ready;
    logic              resp_valid;
    logic              resp_hit;
    logic [1:0]        resp_kind;
    logic [DATA_W-1:0] resp_data;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;

    always #2.5 clk = ~clk;

    setassoc_lru_cache #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CACHE_BYTES (CACHE_BYTES),
        .BLOCK_WORDS (BLOCK_WORDS),
        .WAYS        (WAYS),
        .MEM_LAT     (MEM_LAT)
    ) u_setassoc_lru_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_byte    (req_byte),
        .req_ready   (req_ready),
        .resp_valid  (resp_valid),
        .resp_hit    (resp_hit),
        .resp_kind   (resp_kind),
        .resp_data   (resp_data),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    // Main memory: contents are a function of the word address.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ((a >> 2) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    logic [31:0] pipe [MEM_LAT];
    always @(posedge clk) begin
        pipe[0] <= mem_rd_en ? mem_word(mem_rd_addr) : 32'hDEAD_BEEF;
        for (int i = 1; i < MEM_LAT; i++) pipe[i] <= pipe[i-1];
        if (mem_rd_en) rd_count <= rd_count + 1;
    end
    assign mem_rd_data = pipe[MEM_LAT-1];

    // Reference model of the same geometry.
    int          m_valid [SETS][WAYS];
    logic [31:0] m_tag   [SETS][WAYS];
    int          m_age   [SETS][WAYS];

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0;
                m_tag[s][w]   = '0;
                m_age[s][w]   = w;
            end
    endtask

    task automatic model_touch(input int s, input int h);
        int a0;
        a0 = m_age[s][h];
        for (int w = 0; w < WAYS; w++) begin
            if (w == h) m_age[s][w] = 0;
            else if (m_age[s][w] < a0) m_age[s][w] = m_age[s][w] + 1;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input bit is_b);
        int s, h, v, lat, rd0;
        logic [31:0] t, w, exp_data;
        logic [1:0]  exp_kind;
        bit          exp_hit;
        // R1: field split used by the model
        s = int'((a >> LOW_W) & (SETS - 1));
        t = a >> (LOW_W + IDX_W);
        h = -1;
        for (int i = 0; i < WAYS; i++)
            if (m_valid[s][i] != 0 && m_tag[s][i] == t) h = i;
        exp_hit = (h >= 0);
        if (exp_hit) begin
            exp_kind = 2'b00;
        end else begin
            v = -1;
            for (int i = WAYS - 1; i >= 0; i--) if (m_valid[s][i] == 0) v = i;
            if (v >= 0) begin
                exp_kind = 2'b01;
            end else begin
                exp_kind = 2'b10;
                for (int i = 0; i < WAYS; i++) if (m_age[s][i] == WAYS - 1) v = i;
            end
            h = v;
            m_valid[s][h] = 1;
            m_tag[s][h]   = t;
        end
        model_touch(s, h);
        w = mem_word({a[31:2], 2'b00});
        exp_data = is_b ? {24'h0, w[{a[1:0], 3'b000} +: 8]} : w;

        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_byte  = is_b;
        rd0       = rd_count;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(resp_hit == exp_hit, "R2", $sformatf("hit flag @%h", a),
              32'(resp_hit), 32'(exp_hit));
        check(resp_kind == exp_kind, exp_kind == 2'b10 ? "R7/R8" :
              (exp_kind == 2'b01 ? "R6" : "R3"), $sformatf("kind @%h", a),
              32'(resp_kind), 32'(exp_kind));
        check(resp_data == exp_data, is_b ? "R9" : "R5", $sformatf("data @%h", a),
              resp_data, exp_data);
        check(lat == (exp_hit ? 1 : MISS_LAT), "R4", $sformatf("latency @%h", a),
              32'(lat), 32'(exp_hit ? 1 : MISS_LAT));
        check(rd_count - rd0 == (exp_hit ? 0 : BLOCK_WORDS), "R4",
              $sformatf("memory reads @%h", a), 32'(rd_count - rd0),
              32'(exp_hit ? 0 : BLOCK_WORDS));
    endtask

    // Stimulus table: {address, byte-load flag}.
    localparam int NVEC = 16;
    localparam logic [32:0] VEC [NVEC] = '{
        {32'h0000_1020, 1'b0},  // R1 set A, tag X: cold
        {32'h0000_1027, 1'b1},  // R9 byte lane 3 of word 1: hit
        {32'h0000_1220, 1'b0},  // R1 same set, tag Y: cold into next way
        {32'h0000_102C, 1'b0},  // R8 refresh tag X
        {32'h0000_1420, 1'b1},  // R7 tag Z evicts LRU
        {32'h0000_1221, 1'b1},  // R7 eviction order after refresh
        {32'h0000_1024, 1'b0},
        {32'h0000_1428, 1'b0},
        {32'h0000_0F3C, 1'b0},  // other set
        {32'h0000_0F31, 1'b1},  // R5 other word of same block
        {32'hFFFF_FFFE, 1'b1},  // top of address space
        {32'hFFFF_FFF0, 1'b0},
        {32'h0000_1030, 1'b0},
        {32'h0000_103D, 1'b1},
        {32'h0000_1422, 1'b1},
        {32'h0000_122F, 1'b1}
    };

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        // R11: reset state
        check(req_ready == 1'b1, "R11", "req_ready in reset", 32'(req_ready), 32'd1);
        check(resp_valid == 1'b0, "R11", "resp_valid in reset", 32'(resp_valid), 32'd0);
        check(mem_rd_en == 1'b0, "R11", "mem_rd_en in reset", 32'(mem_rd_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && resp_valid == 1'b0, "R11", "idle after reset",
              32'({req_ready, resp_valid}), 32'h2);

        for (int i = 0; i < NVEC; i++) access(VEC[i][32:1], VEC[i][0]);

        // R2: reset clears valid state, so a cached block misses again.
        access(32'h0000_0F34, 1'b0);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(32'h0000_0F34, 1'b0);
        access(32'h0000_0F36, 1'b1);
        // R9: word load ignores low address bits
        access(32'h0000_0F37, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule